// File: doc/BRIEF.md
# TDM Slot Receiver with Mono Selection

This block takes a serial audio stream (a bit clock, a frame sync and one data line) and turns it into one 32-bit mono sample per frame. The three serial inputs are oversampled by the system clock. A selected bit-clock edge is treated as the sampling instant. The same logic serves I2S, left-justified and multi-slot TDM streams: the format is set entirely by static configuration inputs.

The frame begins at a chosen transition of frame sync. Slot 0 starts a programmable number of bit clocks after that transition. The slots are 16, 24 or 32 bits wide, and each carries an audio word that sits at the start or at the end of the slot. Two captures run in parallel. The first follows the slot that the source selector names, which may be a default slot given by an address input. The second follows the right slot, which the down-mix needs. When the next frame boundary arrives, the block issues the selected slot, or the average of left and right, as an MSB-aligned word together with a one-cycle valid.

A slot that does not fit completely inside the frame contributes a zero sample. The configuration is expected to stay static while frames are flowing. Reset is asynchronous and active-low, and the block assumes it is released synchronously to `clk`.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is asserted, `mono_valid` is 0 and `mono_data` is 0.
- R2: A frame starts at a rising transition of the sampled frame sync when `cfg_fs_fall` is 0, and at a falling transition when it is 1. The opposite transition has no effect on framing.
- R3: Frame sync and data are sampled on rising bit-clock edges when `cfg_bclk_fall` is 0, and on falling edges when it is 1.
- R4: The sample in which the frame-start transition is seen is bit position 0. Slot 0 begins at bit position `cfg_offset` (0 to 31), and slot k begins at `cfg_offset` + k × slot length.
- R5: `cfg_slot_len` selects the slot length: code 00 gives 16 bits, code 01 gives 24 bits, and codes 10 and 11 give 32 bits.
- R6: `cfg_word_len` selects the word length: 00 gives 16, 01 gives 20, 10 gives 24 and 11 gives 32 bits. A word longer than the slot is cut to the slot length.
- R7: With `cfg_right_just` at 0, the word occupies the first bits of the slot, MSB first. With it at 1, the word occupies the last bits of the slot. All other bits of the slot are ignored.
- R8: `cfg_mono_src` selects the output: 00 gives the slot numbered by `addr_slot`, 01 the slot `cfg_left_slot`, 10 the slot `cfg_right_slot`, and 11 the down-mix.
- R9: The down-mix is the signed sum of the left and right words shifted right arithmetically by one, which is floor((L+R)/2) on 32-bit MSB-aligned values.
- R10: A slot whose last bit position is at or beyond the frame length counts as a zero sample. The frame length is the number of bit positions before the next frame start.
- R11: The output word is MSB-aligned with zero low bits. Each frame start after the first one since reset closes the previous frame and produces exactly one single-cycle `mono_valid` pulse. The first frame start after reset produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| sdin | input | 1 | Serial audio data |
| cfg_fs_fall | input | 1 | 0: frame starts on rising sync, 1: on falling sync |
| cfg_bclk_fall | input | 1 | 0: sample on rising bit clock, 1: on falling |
| cfg_offset | input | 5 | Bit clocks from frame start to slot 0 |
| cfg_slot_len | input | 2 | Slot length code |
| cfg_word_len | input | 2 | Word length code |
| cfg_right_just | input | 1 | 1: word right-justified in slot |
| cfg_left_slot | input | 4 | Left slot number |
| cfg_right_slot | input | 4 | Right slot number |
| cfg_mono_src | input | 2 | Mono source select |
| addr_slot | input | 4 | Default mono slot number |
| mono_data | output | 32 | MSB-aligned mono sample |
| mono_valid | output | 1 | One-cycle strobe per completed frame |

## Verification
The assertions check on every cycle how the output strobe relates to frame boundaries. A valid appears exactly one cycle after every synced frame start and at no other time, and it never lasts two cycles. They also check that slot counting restarts at a boundary, that slot completion only changes on a sampling strobe, and that an incomplete selected slot produces a zero word. The bench scenarios are needed for everything that depends on the bit layout. That covers the offset, the slot and word lengths, justification and truncation. It also covers sync polarity and sampling edge, where data that changes shortly after the launch edge shows up any sampling on the wrong edge. The remaining cases are the signed rounding of the down-mix and the exact-fit versus overrun boundary at the end of the frame.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int SMP_W = 32;
  localparam int LEN_W = $clog2(SMP_W) + 1;

  typedef enum logic [1:0] {
    SRC_ADDR  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_MIX   = 2'b11
  } mono_src_e;

  function automatic logic [LEN_W-1:0] slot_bits(input logic [1:0] code);
    case (code)
      2'b00:   return LEN_W'(16);
      2'b01:   return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] word_bits(input logic [1:0] code,
                                                 input logic [LEN_W-1:0] slen);
    logic [LEN_W-1:0] w;
    case (code)
      2'b00:   w = LEN_W'(16);
      2'b01:   w = LEN_W'(20);
      2'b10:   w = LEN_W'(24);
      default: w = LEN_W'(32);
    endcase
    return (w > slen) ? slen : w;
  endfunction

endpackage

// File: rtl/tdm_rx_sampler.sv
module tdm_rx_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic sdin,
  input  logic cfg_bclk_fall,
  output logic strobe,
  output logic fs_bit,
  output logic data_bit
);

  logic bclk_q, bclk_qq, fs_q, sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      fs_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      bclk_qq <= bclk_q;
      fs_q    <= fsync;
      sd_q    <= sdin;
    end
  end

  // sampling instant: the chosen bit-clock transition seen in the registered copy
  always_comb begin
    strobe   = cfg_bclk_fall ? (bclk_qq & ~bclk_q) : (~bclk_qq & bclk_q);
    fs_bit   = fs_q;
    data_bit = sd_q;
  end

  // R3: two sampling strobes never fall in adjacent cycles
  a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             fs_bit,
  input  logic             cfg_fs_fall,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic [LEN_W-1:0] slen,
  output logic             frame_start,
  output logic             in_slot,
  output logic [LEN_W-2:0] cur_bit,
  output logic [IDX_W-1:0] cur_idx,
  output logic             synced
);

  logic             fs_prev_r, fs_prev_n;
  logic [OFF_W-1:0] lead_r, lead_n, c_lead;
  logic [LEN_W-2:0] bit_r, bit_n;
  logic [IDX_W-1:0] idx_r, idx_n;
  logic             synced_r, synced_n;

  always_comb begin
    frame_start = strobe && (fs_bit != fs_prev_r) && (fs_bit != cfg_fs_fall);
    if (frame_start) begin
      c_lead  = cfg_offset;
      cur_bit = '0;
      cur_idx = '0;
    end else begin
      c_lead  = lead_r;
      cur_bit = bit_r;
      cur_idx = idx_r;
    end
    in_slot = (c_lead == '0);
    synced  = synced_r;

    fs_prev_n = fs_bit;
    synced_n  = synced_r | frame_start;
    if (!in_slot) begin
      lead_n = c_lead - 1'b1;
      bit_n  = '0;
      idx_n  = '0;
    end else if ({1'b0, cur_bit} == slen - 1'b1) begin
      lead_n = c_lead;
      bit_n  = '0;
      idx_n  = (cur_idx == '1) ? cur_idx : cur_idx + 1'b1;
    end else begin
      lead_n = c_lead;
      bit_n  = cur_bit + 1'b1;
      idx_n  = cur_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_r <= 1'b0;
      lead_r    <= '0;
      bit_r     <= '0;
      idx_r     <= '0;
      synced_r  <= 1'b0;
    end else if (strobe) begin
      fs_prev_r <= fs_prev_n;
      lead_r    <= lead_n;
      bit_r     <= bit_n;
      idx_r     <= idx_n;
      synced_r  <= synced_n;
    end
  end

  // R4: every frame boundary restarts slot numbering at slot 0
  a_r4_frame_restarts_slots: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (idx_r == '0));

  // R4: slot index never goes backwards inside a frame
  a_r4_idx_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !frame_start) |=> (idx_r >= $past(idx_r)));

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
  import tdm_rx_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             frame_start,
  input  logic             in_slot,
  input  logic [LEN_W-2:0] cur_bit,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             data_bit,
  input  logic [SEL_W-1:0] slot_sel,
  input  logic [LEN_W-1:0] slen,
  input  logic [LEN_W-1:0] wlen,
  input  logic             rjust,
  output logic [SMP_W-1:0] sample,
  output logic             done
);

  logic [SMP_W-1:0] acc_r, acc_n;
  logic             done_r, done_n;
  logic             hit, in_word;
  logic [LEN_W-1:0] pos, shamt;

  always_comb begin
    pos     = {1'b0, cur_bit};
    hit     = strobe && in_slot && (cur_idx == IDX_W'(slot_sel));
    in_word = rjust ? (pos >= slen - wlen) : (pos < wlen);

    acc_n  = frame_start ? '0 : acc_r;
    done_n = frame_start ? 1'b0 : done_r;
    if (hit && in_word) acc_n = {acc_n[SMP_W-2:0], data_bit};
    if (hit && (pos == slen - 1'b1)) done_n = 1'b1;

    shamt  = LEN_W'(SMP_W) - wlen;
    sample = done_r ? (acc_r << shamt) : '0;
    done   = done_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r  <= '0;
      done_r <= 1'b0;
    end else if (strobe) begin
      acc_r  <= acc_n;
      done_r <= done_n;
    end
  end

  // R10: completion state only moves on a sampling strobe
  a_r10_done_on_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(done_r));

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int SEL_W = 4,
  parameter int IDX_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             sdin,
  input  logic             cfg_fs_fall,
  input  logic             cfg_bclk_fall,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic [1:0]       cfg_slot_len,
  input  logic [1:0]       cfg_word_len,
  input  logic             cfg_right_just,
  input  logic [SEL_W-1:0] cfg_left_slot,
  input  logic [SEL_W-1:0] cfg_right_slot,
  input  logic [1:0]       cfg_mono_src,
  input  logic [SEL_W-1:0] addr_slot,
  output logic [SMP_W-1:0] mono_data,
  output logic             mono_valid
);

  localparam int N_CAP = 2;

  logic             strobe, fs_bit, data_bit;
  logic             frame_start, in_slot, synced;
  logic [LEN_W-2:0] cur_bit;
  logic [IDX_W-1:0] cur_idx;
  logic [LEN_W-1:0] slen, wlen;
  mono_src_e        src;
  logic [SEL_W-1:0] cap_sel  [N_CAP];
  logic [SMP_W-1:0] cap_smp  [N_CAP];
  logic             cap_done [N_CAP];
  logic [SMP_W:0]   mix_sum;
  logic [SMP_W-1:0] data_r, data_n;
  logic             valid_r, valid_n;

  always_comb begin
    slen = slot_bits(cfg_slot_len);
    wlen = word_bits(cfg_word_len, slen);
    src  = mono_src_e'(cfg_mono_src);
    case (src)
      SRC_ADDR:  cap_sel[0] = addr_slot;
      SRC_RIGHT: cap_sel[0] = cfg_right_slot;
      default:   cap_sel[0] = cfg_left_slot;
    endcase
    cap_sel[1] = cfg_right_slot;
  end

  tdm_rx_sampler u_sampler (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk          (bclk),
    .fsync         (fsync),
    .sdin          (sdin),
    .cfg_bclk_fall (cfg_bclk_fall),
    .strobe        (strobe),
    .fs_bit        (fs_bit),
    .data_bit      (data_bit)
  );

  tdm_rx_framer #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .fs_bit      (fs_bit),
    .cfg_fs_fall (cfg_fs_fall),
    .cfg_offset  (cfg_offset),
    .slen        (slen),
    .frame_start (frame_start),
    .in_slot     (in_slot),
    .cur_bit     (cur_bit),
    .cur_idx     (cur_idx),
    .synced      (synced)
  );

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    tdm_rx_capture #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (strobe),
      .frame_start (frame_start),
      .in_slot     (in_slot),
      .cur_bit     (cur_bit),
      .cur_idx     (cur_idx),
      .data_bit    (data_bit),
      .slot_sel    (cap_sel[g]),
      .slen        (slen),
      .wlen        (wlen),
      .rjust       (cfg_right_just),
      .sample      (cap_smp[g]),
      .done        (cap_done[g])
    );
  end

  always_comb begin
    mix_sum = {cap_smp[0][SMP_W-1], cap_smp[0]} + {cap_smp[1][SMP_W-1], cap_smp[1]};
    valid_n = frame_start && synced;
    data_n  = (src == SRC_MIX) ? mix_sum[SMP_W:1] : cap_smp[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_r <= 1'b0;
      data_r  <= '0;
    end else begin
      valid_r <= valid_n;
      if (valid_n) data_r <= data_n;
    end
  end

  assign mono_data  = data_r;
  assign mono_valid = valid_r;

  // R11: a synced boundary always yields a strobe in the next cycle
  a_r11_valid_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && synced) |=> mono_valid);

  // R11: no strobe without a synced boundary
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && synced) |=> !mono_valid);

  // R11: strobe is one cycle wide
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mono_valid |=> !mono_valid);

  // R10: an incomplete single-slot selection comes out as zero
  a_r10_muted_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && synced && (src != SRC_MIX) && !cap_done[0]) |=> (mono_data == '0));

endmodule

// File: tb/tdm_slot_rx_tb.sv
module tdm_slot_rx_tb;

  logic        clk, rst_n;
  logic        bclk, fsync, sdin;
  logic        cfg_fs_fall, cfg_bclk_fall, cfg_right_just;
  logic [4:0]  cfg_offset;
  logic [1:0]  cfg_slot_len, cfg_word_len, cfg_mono_src;
  logic [3:0]  cfg_left_slot, cfg_right_slot, addr_slot;
  logic [31:0] mono_data;
  logic        mono_valid;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] slot_val [16];

  tdm_slot_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .cfg_fs_fall(cfg_fs_fall), .cfg_bclk_fall(cfg_bclk_fall),
    .cfg_offset(cfg_offset), .cfg_slot_len(cfg_slot_len),
    .cfg_word_len(cfg_word_len), .cfg_right_just(cfg_right_just),
    .cfg_left_slot(cfg_left_slot), .cfg_right_slot(cfg_right_slot),
    .cfg_mono_src(cfg_mono_src), .addr_slot(addr_slot),
    .mono_data(mono_data), .mono_valid(mono_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL [%s] actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench model of the configuration (R5, R6)
  function automatic int b_slen();
    case (cfg_slot_len)
      2'b00: return 16;
      2'b01: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int b_wlen();
    int w;
    case (cfg_word_len)
      2'b00: w = 16;
      2'b01: w = 20;
      2'b10: w = 24;
      default: w = 32;
    endcase
    return (w > b_slen()) ? b_slen() : w;
  endfunction

  // serial bit at position p; unused bits are padded with ones
  function automatic logic frame_bit(input int p);
    int sl, w, rel, k, j;
    sl = b_slen();
    w  = b_wlen();
    if (p < int'(cfg_offset)) return 1'b1;
    rel = p - int'(cfg_offset);
    k = rel / sl;
    j = rel % sl;
    if (k > 15) return 1'b1;
    if (!cfg_right_just) begin
      if (j < w) return slot_val[k][31-j];
    end else if (j >= sl - w) begin
      return slot_val[k][31-(j-(sl-w))];
    end
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_slot(input int k, input int n);
    int sl, w;
    sl = b_slen();
    w  = b_wlen();
    if (int'(cfg_offset) + (k + 1) * sl > n) return 32'h0;
    return slot_val[k] & (32'hFFFF_FFFF << (32 - w));
  endfunction

  function automatic logic [31:0] exp_mono(input int n);
    logic [32:0] s;
    case (cfg_mono_src)
      2'b00: return exp_slot(int'(addr_slot), n);
      2'b01: return exp_slot(int'(cfg_left_slot), n);
      2'b10: return exp_slot(int'(cfg_right_slot), n);
      default: begin
        s = $signed({exp_slot(int'(cfg_left_slot), n)[31], exp_slot(int'(cfg_left_slot), n)})
          + $signed({exp_slot(int'(cfg_right_slot), n)[31], exp_slot(int'(cfg_right_slot), n)});
        return s[32:1];
      end
    endcase
  endfunction

  // one bit clock period: launch edge, data change one clk later, then sample edge
  task automatic drive_bit(input logic fs, input logic d);
    @(negedge clk); bclk = cfg_bclk_fall;
    @(negedge clk); fsync = fs; sdin = d;
    @(negedge clk);
    @(negedge clk); bclk = ~cfg_bclk_fall;
    @(negedge clk);
  endtask

  task automatic run_scen(input string tag, input int n, input int fsw,
                          input int nfr, input int seed);
    logic act;
    act = ~cfg_fs_fall;
    rst_n = 1'b0;
    bclk  = ~cfg_bclk_fall;
    fsync = ~act;
    sdin  = 1'b0;
    repeat (3) @(negedge clk);
    check(!mono_valid && mono_data == 32'h0, "R1 reset", {mono_valid, mono_data[30:0]}, 32'h0);
    rst_n = 1'b1;
    drive_bit(~act, 1'b0);
    drive_bit(~act, 1'b0);
    for (int f = 0; f < nfr; f++) begin
      for (int k = 0; k < 16; k++)
        slot_val[k] = 32'h9E37_79B9 * (seed * 64 + f * 16 + k + 1) ^ 32'h5A5A_0F0F;
      exp_q.push_back(exp_mono(n));
      tag_q.push_back(tag);
      for (int p = 0; p < n; p++)
        drive_bit((p < fsw) ? act : ~act, frame_bit(p));
    end
    drive_bit(act, 1'b0);
    drive_bit(~act, 1'b0);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R11 one strobe per frame", exp_q.size(), 32'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mono_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected strobe", mono_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mono_data == e, t, mono_data, e);
      end
    end
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL [watchdog] actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sdin = 1'b0;
    cfg_fs_fall = 1'b0; cfg_bclk_fall = 1'b0; cfg_right_just = 1'b0;
    cfg_offset = 5'd0; cfg_slot_len = 2'b10; cfg_word_len = 2'b11;
    cfg_left_slot = 4'd0; cfg_right_slot = 4'd1; cfg_mono_src = 2'b01;
    addr_slot = 4'd0;

    // I2S-like: falling sync start, offset 1, 24-bit words in 32-bit slots, left
    cfg_fs_fall = 1'b1; cfg_offset = 5'd1; cfg_slot_len = 2'b10; cfg_word_len = 2'b10;
    cfg_mono_src = 2'b01;
    run_scen("R2 R4 R7 R8 left", 64, 32, 3, 1);

    // same format, right slot, full 32-bit words
    cfg_word_len = 2'b11; cfg_mono_src = 2'b10;
    run_scen("R2 R6 R8 right", 64, 32, 2, 2);

    // TDM: rising sync, falling-edge sampling, 16-bit slots, default slot 3
    cfg_fs_fall = 1'b0; cfg_bclk_fall = 1'b1; cfg_offset = 5'd0;
    cfg_slot_len = 2'b00; cfg_word_len = 2'b00; cfg_mono_src = 2'b00;
    addr_slot = 4'd3; cfg_left_slot = 4'd5; cfg_right_slot = 4'd6;
    run_scen("R3 R5 R8 addr slot", 128, 1, 3, 3);

    // down-mix of right-justified 20-bit words in 24-bit slots, offset 3
    cfg_bclk_fall = 1'b0; cfg_offset = 5'd3; cfg_slot_len = 2'b01; cfg_word_len = 2'b01;
    cfg_right_just = 1'b1; cfg_left_slot = 4'd2; cfg_right_slot = 4'd5;
    cfg_mono_src = 2'b11;
    run_scen("R4 R5 R7 R9 mix", 200, 1, 3, 4);

    // 32-bit word code in a 16-bit slot is cut to 16 bits
    cfg_offset = 5'd0; cfg_slot_len = 2'b00; cfg_word_len = 2'b11; cfg_right_just = 1'b0;
    cfg_left_slot = 4'd1; cfg_mono_src = 2'b01;
    run_scen("R6 truncate", 64, 1, 2, 5);

    // right slot 7 overruns frame by one bit: mix sees only left
    cfg_offset = 5'd1; cfg_slot_len = 2'b11; cfg_word_len = 2'b10;
    cfg_left_slot = 4'd6; cfg_right_slot = 4'd7; cfg_mono_src = 2'b11;
    run_scen("R10 R9 partial overrun", 256, 1, 2, 6);

    // exact fit: slot 7 ends on the last bit of the frame
    cfg_offset = 5'd0; cfg_mono_src = 2'b10;
    run_scen("R10 exact fit", 256, 1, 2, 7);

    // slot entirely beyond the frame end is muted
    cfg_left_slot = 4'd9; cfg_mono_src = 2'b01;
    run_scen("R10 beyond frame", 256, 1, 2, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule